// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator machine. A micro-program counter (micro-PC) addresses an internal control store, and the word it selects drives the datapath control bus for exactly one clock cycle. The datapath, memory and ALU sit outside the block. The block only reads the 4-bit opcode that the instruction register holds and a 4-bit condition-flag vector, and it drives a 16-bit bus of active-high strobes.

Every instruction starts with the same three-cycle fetch micro-routine and a decode cycle. In the decode cycle an opcode decoder loads the micro-PC with the entry address of that opcode's execute routine. Each microword has a sequencing field. The field picks the next micro-address: the next word, back to fetch, the decoder output, a flag-qualified step, or a hold. Conditional jumps therefore finish in one cycle when the flag is clear and in two cycles when it is set.

Top module: `microseq_ctl`

## Requirements
- R1: While `rst` is high, each clock edge forces `upc` to 0. On the first cycle after release, `ctrl` equals 16'h0001 (only bit 0, PC onto address bus).
- R2: The fetch routine drives three cycles with one strobe each, in this order: bit 0 (PC read), bit 1 (memory read), bit 3 (IR load).
- R3: The fourth cycle is the decode step. It asserts only bit 5 (PC increment). At the following edge, `upc` leaves the fetch/decode range (becomes 4 or more), chosen by `opcode`.
- R4: LOAD (opcode 1) drives bit 14 (IR operand to address), then bits 1 and 4 (memory read, accumulator load). STORE (opcode 2) drives bit 14, then bits 7 and 2 (accumulator to data bus, memory write).
- R5: ADD (3) drives bit 14, then bits 1 and 8 (B-register load), then bits 9, 4 and 13 (ALU result out, accumulator load, flag load). SUB (4) does the same with bit 10 (ALU subtract) added to its last word. CMP (10) drives bit 14, then bits 1 and 8, then bits 10 and 13 only.
- R6: IN (5) drives bits 11 and 4 (I/O read, accumulator load) for one cycle. OUT (6) drives bits 7 and 12 (I/O write) for one cycle.
- R7: JUMP (7) drives bits 14 and 6 (PC load) for one cycle.
- R8: The conditional jumps are opcode 8 on `flags[0]` (negative), 11 on `flags[1]` (greater), 12 on `flags[2]` (equal) and 13 on `flags[3]` (less). Each spends one cycle with no strobe. When its flag is set, a cycle with bits 14 and 6 follows. When its flag is clear, fetch follows at once.
- R9: HALT (9) drives only bit 15 and holds `upc` unchanged on every edge until reset.
- R10: Opcodes 0, 14 and 15 spend one cycle with no strobe and then return to fetch.
- R11: After the last word of every routine except HALT, the next cycle has `upc` equal to 0 and `ctrl` equal to 16'h0001.
- R12: Memory read (bit 1) and memory write (bit 2) are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field of the instruction register |
| flags | input | 4 | Condition flags: negative, greater, equal, less (bits 0..3) |
| ctrl | output | 16 | Control bus of active-high strobes |
| upc | output | 5 | Current micro-PC |

## Verification
The bench builds the block at its default widths: a 4-bit opcode, 4 flags and a 5-bit micro-PC. At these widths the whole input space is small enough to sweep in full. Every one of the 16 opcodes runs from reset against every one of the 16 flag patterns. Each microword is compared with a bench-side table of expected strobes. This covers taken and untaken forms of each conditional jump with unrelated flags set, the unused opcodes, and reset arriving while the sequencer is halted.

// File: rtl/microseq_ctl.sv
module microseq_ctl #(
  parameter int OP_W   = 4,
  parameter int FLAG_W = 4,
  parameter int UA_W   = 5,
  parameter int CW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic [FLAG_W-1:0] flags,
  output logic [CW-1:0]     ctrl,
  output logic [UA_W-1:0]   upc
);
  localparam int SEL_W = $clog2(FLAG_W);

  localparam logic [2:0] SQ_NEXT  = 3'd0;
  localparam logic [2:0] SQ_FETCH = 3'd1;
  localparam logic [2:0] SQ_DEC   = 3'd2;
  localparam logic [2:0] SQ_COND  = 3'd3;
  localparam logic [2:0] SQ_HOLD  = 3'd4;

  localparam logic [CW-1:0] C_NONE  = '0;
  localparam logic [CW-1:0] C_PCRD  = CW'(1) << 0;
  localparam logic [CW-1:0] C_MRD   = CW'(1) << 1;
  localparam logic [CW-1:0] C_MWR   = CW'(1) << 2;
  localparam logic [CW-1:0] C_IRLD  = CW'(1) << 3;
  localparam logic [CW-1:0] C_ACLD  = CW'(1) << 4;
  localparam logic [CW-1:0] C_PCINC = CW'(1) << 5;
  localparam logic [CW-1:0] C_PCLD  = CW'(1) << 6;
  localparam logic [CW-1:0] C_ACRD  = CW'(1) << 7;
  localparam logic [CW-1:0] C_BLD   = CW'(1) << 8;
  localparam logic [CW-1:0] C_ALURD = CW'(1) << 9;
  localparam logic [CW-1:0] C_SUB   = CW'(1) << 10;
  localparam logic [CW-1:0] C_IORD  = CW'(1) << 11;
  localparam logic [CW-1:0] C_IOWR  = CW'(1) << 12;
  localparam logic [CW-1:0] C_FLLD  = CW'(1) << 13;
  localparam logic [CW-1:0] C_IRRD  = CW'(1) << 14;
  localparam logic [CW-1:0] C_HALT  = CW'(1) << 15;

  logic [2:0]       seq;
  logic [SEL_W-1:0] csel;
  logic [CW-1:0]    word;
  logic [UA_W-1:0]  entry;
  logic [UA_W-1:0]  upc_nx;

  always_comb begin
    csel = '0;
    seq  = SQ_FETCH;
    word = C_NONE;
    case (int'(upc))
      0:  begin word = C_PCRD;  seq = SQ_NEXT; end
      1:  begin word = C_MRD;   seq = SQ_NEXT; end
      2:  begin word = C_IRLD;  seq = SQ_NEXT; end
      3:  begin word = C_PCINC; seq = SQ_DEC;  end
      4:  word = C_NONE;
      5:  begin word = C_IRRD; seq = SQ_NEXT; end
      6:  word = C_MRD | C_ACLD;
      7:  begin word = C_IRRD; seq = SQ_NEXT; end
      8:  word = C_ACRD | C_MWR;
      9:  begin word = C_IRRD; seq = SQ_NEXT; end
      10: begin word = C_MRD | C_BLD; seq = SQ_NEXT; end
      11: word = C_ALURD | C_ACLD | C_FLLD;
      12: begin word = C_IRRD; seq = SQ_NEXT; end
      13: begin word = C_MRD | C_BLD; seq = SQ_NEXT; end
      14: word = C_ALURD | C_SUB | C_ACLD | C_FLLD;
      15: word = C_IORD | C_ACLD;
      16: word = C_ACRD | C_IOWR;
      17: word = C_IRRD | C_PCLD;
      18: begin seq = SQ_COND; csel = SEL_W'(0); end
      19: word = C_IRRD | C_PCLD;
      20: begin word = C_HALT; seq = SQ_HOLD; end
      21: begin word = C_IRRD; seq = SQ_NEXT; end
      22: begin word = C_MRD | C_BLD; seq = SQ_NEXT; end
      23: word = C_SUB | C_FLLD;
      24: begin seq = SQ_COND; csel = SEL_W'(1); end
      25: word = C_IRRD | C_PCLD;
      26: begin seq = SQ_COND; csel = SEL_W'(2); end
      27: word = C_IRRD | C_PCLD;
      28: begin seq = SQ_COND; csel = SEL_W'(3); end
      29: word = C_IRRD | C_PCLD;
      default: word = C_NONE;
    endcase
  end

  always_comb begin
    case (int'(opcode))
      1:  entry = UA_W'(5);
      2:  entry = UA_W'(7);
      3:  entry = UA_W'(9);
      4:  entry = UA_W'(12);
      5:  entry = UA_W'(15);
      6:  entry = UA_W'(16);
      7:  entry = UA_W'(17);
      8:  entry = UA_W'(18);
      9:  entry = UA_W'(20);
      10: entry = UA_W'(21);
      11: entry = UA_W'(24);
      12: entry = UA_W'(26);
      13: entry = UA_W'(28);
      default: entry = UA_W'(4);
    endcase
  end

  always_comb begin
    case (seq)
      SQ_NEXT: upc_nx = upc + UA_W'(1);
      SQ_DEC:  upc_nx = entry;
      SQ_COND: upc_nx = flags[csel] ? upc + UA_W'(1) : '0;
      SQ_HOLD: upc_nx = upc;
      default: upc_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else     upc <= upc_nx;
  end

  assign ctrl = word;
endmodule

// File: rtl/microseq_ctl_chk.sv
module microseq_ctl_chk #(
  parameter int UA_W = 5,
  parameter int CW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [CW-1:0]   ctrl,
  input logic [UA_W-1:0] upc
);
  assert_reset_R1: assert property (@(posedge clk) rst |=> upc == '0);
  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl[0] && upc == '0) |=> ctrl[1] && !ctrl[0]);
  assert_decode_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl[5] |=> upc >= UA_W'(4));
  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl[15] |=> ctrl[15] && $stable(upc));
  assert_pcld_single_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl[6] |=> upc == '0);
  always_comb assert_mem_excl_R12: assert (!(ctrl[1] && ctrl[2]));
endmodule

bind microseq_ctl microseq_ctl_chk #(.UA_W(UA_W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl), .upc(upc));

// File: tb/microseq_ctl_tb.sv
`timescale 1ns/1ps
module microseq_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = '0;
  logic [3:0]  flags = '0;
  logic [15:0] ctrl;
  logic [4:0]  upc;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  microseq_ctl u_dut (.clk(clk), .rst(rst), .opcode(opcode), .flags(flags),
                      .ctrl(ctrl), .upc(upc));

  function automatic logic [15:0] b(int i);
    return 16'(1) << i;
  endfunction

  function automatic int flag_of(int op);
    case (op)
      8: return 0;
      11: return 1;
      12: return 2;
      13: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic string tag_of(int op);
    case (op)
      1, 2: return "R4";
      3, 4, 10: return "R5";
      5, 6: return "R6";
      7: return "R7";
      8, 11, 12, 13: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic int rlen(int op, logic [3:0] fl);
    case (op)
      1, 2: return 2;
      3, 4, 10: return 3;
      8, 11, 12, 13: return fl[flag_of(op)] ? 2 : 1;
      default: return 1;
    endcase
  endfunction

  function automatic logic [15:0] rword(int op, int k);
    case (op)
      1: return k == 0 ? b(14) : (b(1) | b(4));
      2: return k == 0 ? b(14) : (b(7) | b(2));
      3: return k == 0 ? b(14) : k == 1 ? (b(1) | b(8)) : (b(9) | b(4) | b(13));
      4: return k == 0 ? b(14) : k == 1 ? (b(1) | b(8)) : (b(9) | b(10) | b(4) | b(13));
      10: return k == 0 ? b(14) : k == 1 ? (b(1) | b(8)) : (b(10) | b(13));
      5: return b(11) | b(4);
      6: return b(7) | b(12);
      7: return b(14) | b(6);
      8, 11, 12, 13: return k == 0 ? 16'h0 : (b(14) | b(6));
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s op=%0d flags=%b actual=%h expected=%h", tag, opcode, flags, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run(int op, logic [3:0] fl);
    rst = 1'b1;
    opcode = 4'(op);
    flags = fl;
    tick();
    chk(upc == 5'd0, "R1", 16'(upc), 16'h0);
    rst = 1'b0;
    chk(ctrl == b(0), "R1", ctrl, b(0));
    tick();
    chk(ctrl == b(1), "R2", ctrl, b(1));
    tick();
    chk(ctrl == b(3), "R2", ctrl, b(3));
    tick();
    chk(ctrl == b(5), "R3", ctrl, b(5));
    tick();
    chk(upc >= 5'd4, "R3", 16'(upc), 16'h4);
    if (op == 9) begin
      for (int i = 0; i < 5; i++) begin
        chk(ctrl == b(15), "R9", ctrl, b(15));
        tick();
      end
      rst = 1'b1;
      tick();
      chk(upc == 5'd0, "R1", 16'(upc), 16'h0);
    end else begin
      for (int k = 0; k < rlen(op, fl); k++) begin
        chk(ctrl == rword(op, k), tag_of(op), ctrl, rword(op, k));
        chk(!(ctrl[1] && ctrl[2]), "R12", ctrl, rword(op, k));
        tick();
      end
      chk(ctrl == b(0) && upc == 5'd0, "R11", ctrl, b(0));
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick();
    tick();
    chk(upc == 5'd0, "R1", 16'(upc), 16'h0);
    for (int op = 0; op < 16; op++)
      for (int f = 0; f < 16; f++)
        run(op, 4'(f));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule